// File: doc/BRIEF.md
# Calendar Timekeeping Core

This block is the counting heart of a wall clock with a calendar. A free-running system clock drives it, and a separate one-cycle-wide pulse arrives once per second. On each such pulse the core steps seconds, and carries ripple up through minutes, hours, day of month, month and a two-digit year. A weekday counter steps whenever the day of month steps. Every field is held as packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0], so that a display stage can decode the fields directly.

Three control paths sit around the counters. The hold input freezes everything. The clear input zeroes the time of day and leaves the date alone. Two fast-adjust inputs step the minute field or the day field once per system clock while a rate-enable strobe is high, so a slow strobe gives a visible setting speed. The power-up instant is set by parameters, and it defaults to year 00, month 01, day 01, weekday 1, 00:00:00.

Top module: `cal_clock_core`

## Requirements
- R1: A synchronous active-high reset loads every field with its power-up parameter value (default 00-01-01, weekday 1, 00:00:00).
- R2: Each accepted seconds pulse adds one to the seconds field in packed BCD (tens in [7:4], units in [3:0], units wrap 9 to 0 with a carry into the tens digit). Seconds wrap from 59 to 00 and carry one step into minutes.
- R3: Minutes count 00 to 59 and carry into hours on a wrap. Hours count 00 to 23, and their wrap from 23 to 00 advances the date by one day.
- R4: The day of month runs from 01 up to the length of the current month and then restarts at 01. The lengths are 30 for months 04, 06, 09 and 11, 31 for the other months, and 28 or 29 for month 02. A month rollover steps the month, which wraps from 12 to 01.
- R5: A year counts as leap when its two-digit value is a multiple of 4, including 00. In a leap year month 02 has 29 days.
- R6: Years count 00 to 99. After 99-12-31 23:59:59, the next pulse gives 00-01-01 00:00:00.
- R7: The weekday runs from 1 to 7 and wraps from 7 to 1. It steps exactly when the day of month steps, whether the step comes from a rollover or from a day adjust.
- R8: While hold is high, no field changes, whatever the other inputs do.
- R9: With clear high and hold low, the next edge sets hours, minutes and seconds to 00 and leaves all date fields unchanged. A seconds pulse in that cycle is discarded.
- R10: With the minute-adjust input and the rate strobe both high, each edge adds one to minutes, with 59 wrapping to 00. It never carries into hours, and a seconds pulse in that cycle is discarded.
- R11: With the day-adjust input and the rate strobe both high, each edge advances the day of month and the weekday by one. The day wraps to 01 after the month length, with no carry into the month.
- R12: An adjust input has no effect while the rate strobe is low, and seconds pulses are then counted as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle pulse per second |
| hold | input | 1 | Freeze all fields |
| clear | input | 1 | Zero the time of day |
| adj_min | input | 1 | Minute fast-adjust request |
| adj_day | input | 1 | Day fast-adjust request |
| adj_rate | input | 1 | Rate strobe that qualifies the adjust requests |
| sec_o | output | 8 | Seconds, packed BCD |
| min_o | output | 8 | Minutes, packed BCD |
| hour_o | output | 8 | Hours, packed BCD |
| wday_o | output | 3 | Weekday, 1 to 7 |
| mday_o | output | 8 | Day of month, packed BCD |
| month_o | output | 8 | Month, packed BCD |
| year_o | output | 8 | Two-digit year, packed BCD |

## Verification
On every cycle the assertions check the following:
- the field ranges, and that the day of month stays within the length of its month;
- the freeze under hold;
- the time-only effect of clear;
- the absence of a carry from either adjust path;
- the lock between the weekday and the day of month;
- the 99-to-00 year wrap.

Only the bench's scenarios can show the full cascade. These cover ripple through the carries, a month change at the end of a 31-day month, a 29-day February in year 00, and the whole-field rollover out of 99-12-31. The bench reaches these by using minute adjust to skip most of each hour.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int DIG_W         = 4;
    localparam int FIELD_W       = 2 * DIG_W;
    localparam int WDAY_W        = 3;
    localparam int DAYS_PER_WEEK = 7;

    typedef struct packed {
        logic [DIG_W-1:0] tens;
        logic [DIG_W-1:0] units;
    } bcd2_t;

    typedef struct packed {
        bcd2_t hour;
        bcd2_t minute;
        bcd2_t second;
    } tod_t;

    typedef struct packed {
        bcd2_t             year;
        bcd2_t             month;
        bcd2_t             mday;
        logic [WDAY_W-1:0] wday;
    } date_t;

    // Add one to a two-digit BCD value (no range limit applied here).
    function automatic bcd2_t bcd_inc(input bcd2_t v);
        bcd2_t r;
        if (v.units == DIG_W'(9)) begin
            r.units = '0;
            r.tens  = v.tens + DIG_W'(1);
        end else begin
            r.units = v.units + DIG_W'(1);
            r.tens  = v.tens;
        end
        return r;
    endfunction

    // Multiple of four test on a BCD year: even tens need units 0/4/8,
    // odd tens need units 2/6.
    function automatic logic leap_year(input bcd2_t y);
        logic r;
        if (!y.tens[0])
            r = (y.units == DIG_W'(0)) || (y.units == DIG_W'(4)) || (y.units == DIG_W'(8));
        else
            r = (y.units == DIG_W'(2)) || (y.units == DIG_W'(6));
        return r;
    endfunction

    // Last valid day of a month, in BCD.
    function automatic bcd2_t month_last_day(input bcd2_t m, input logic leap);
        bcd2_t r;
        case ({m.tens, m.units})
            8'h02:                      r = leap ? bcd2_t'(8'h29) : bcd2_t'(8'h28);
            8'h04, 8'h06, 8'h09, 8'h11: r = bcd2_t'(8'h30);
            default:                    r = bcd2_t'(8'h31);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cal_bcd_cnt.sv
module cal_bcd_cnt
    import cal_pkg::*;
#(
    parameter logic [FIELD_W-1:0] RST_VAL = '0,
    parameter logic [FIELD_W-1:0] LOW_VAL = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  step,
    input  bcd2_t top_val,
    output bcd2_t q,
    output logic  at_top
);

    bcd2_t q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= bcd2_t'(RST_VAL);
        else if (clr)
            q_r <= bcd2_t'(LOW_VAL);
        else if (step)
            q_r <= (q_r == top_val) ? bcd2_t'(LOW_VAL) : bcd_inc(q_r);
    end

    assign q      = q_r;
    assign at_top = (q_r == top_val);

endmodule

// File: rtl/cal_wday_cnt.sv
module cal_wday_cnt
    import cal_pkg::*;
#(
    parameter logic [WDAY_W-1:0] RST_VAL = WDAY_W'(1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [WDAY_W-1:0] q
);

    localparam logic [WDAY_W-1:0] LAST  = WDAY_W'(DAYS_PER_WEEK);
    localparam logic [WDAY_W-1:0] FIRST = WDAY_W'(1);

    logic [WDAY_W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= RST_VAL;
        else if (step)
            q_r <= (q_r == LAST) ? FIRST : q_r + WDAY_W'(1);
    end

    assign q = q_r;

endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
    import cal_pkg::*;
#(
    parameter logic [FIELD_W-1:0] RST_HOUR = '0,
    parameter logic [FIELD_W-1:0] RST_MIN  = '0,
    parameter logic [FIELD_W-1:0] RST_SEC  = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    input  logic min_adj,
    output tod_t tod,
    output logic day_carry
);

    localparam int N       = 3;
    localparam int MIN_IDX = 1;
    // Index 0 is seconds, 1 minutes, 2 hours.
    localparam logic [N*FIELD_W-1:0] TOPS = {8'h23, 8'h59, 8'h59};
    localparam logic [N*FIELD_W-1:0] RSTS = {RST_HOUR, RST_MIN, RST_SEC};

    logic [N:0]   carry;
    logic [N-1:0] at_top;
    logic [N-1:0] step;
    bcd2_t        val [N];

    assign carry[0] = tick;

    for (genvar i = 0; i < N; i++) begin : g_fld
        assign carry[i+1] = carry[i] & at_top[i];
        if (i == MIN_IDX) begin : g_adj
            assign step[i] = carry[i] | min_adj;
        end else begin : g_plain
            assign step[i] = carry[i];
        end
        cal_bcd_cnt #(
            .RST_VAL(RSTS[i*FIELD_W +: FIELD_W]),
            .LOW_VAL('0)
        ) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr),
            .step   (step[i]),
            .top_val(bcd2_t'(TOPS[i*FIELD_W +: FIELD_W])),
            .q      (val[i]),
            .at_top (at_top[i])
        );
    end

    assign tod.second = val[0];
    assign tod.minute = val[1];
    assign tod.hour   = val[2];
    assign day_carry  = carry[N];

endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
    import cal_pkg::*;
#(
    parameter logic [FIELD_W-1:0] RST_YEAR  = 8'h00,
    parameter logic [FIELD_W-1:0] RST_MONTH = 8'h01,
    parameter logic [FIELD_W-1:0] RST_MDAY  = 8'h01,
    parameter logic [WDAY_W-1:0]  RST_WDAY  = WDAY_W'(1)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  roll,
    input  logic  day_adj,
    output date_t date
);

    localparam int N = 3;
    // Index 0 is day of month, 1 month, 2 year.
    localparam logic [N*FIELD_W-1:0] RSTS = {RST_YEAR, RST_MONTH, RST_MDAY};
    localparam logic [N*FIELD_W-1:0] LOWS = {8'h00, 8'h01, 8'h01};

    logic [N-1:0] carry;
    logic [N-1:0] at_top;
    logic [N-1:0] step;
    bcd2_t        val  [N];
    bcd2_t        tops [N];
    logic         day_step;

    assign tops[0] = month_last_day(val[1], leap_year(val[2]));
    assign tops[1] = bcd2_t'(8'h12);
    assign tops[2] = bcd2_t'(8'h99);

    assign carry[0] = roll;
    assign day_step = roll | day_adj;

    for (genvar i = 0; i < N; i++) begin : g_fld
        if (i < N - 1) begin : g_carry
            assign carry[i+1] = carry[i] & at_top[i];
        end
        if (i == 0) begin : g_adj
            assign step[i] = day_step;
        end else begin : g_plain
            assign step[i] = carry[i];
        end
        cal_bcd_cnt #(
            .RST_VAL(RSTS[i*FIELD_W +: FIELD_W]),
            .LOW_VAL(LOWS[i*FIELD_W +: FIELD_W])
        ) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .clr    (1'b0),
            .step   (step[i]),
            .top_val(tops[i]),
            .q      (val[i]),
            .at_top (at_top[i])
        );
    end

    cal_wday_cnt #(
        .RST_VAL(RST_WDAY)
    ) u_wday (
        .clk (clk),
        .rst (rst),
        .step(day_step),
        .q   (date.wday)
    );

    assign date.mday  = val[0];
    assign date.month = val[1];
    assign date.year  = val[2];

endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
    import cal_pkg::*;
#(
    parameter logic [7:0] INIT_YEAR  = 8'h00,
    parameter logic [7:0] INIT_MONTH = 8'h01,
    parameter logic [7:0] INIT_MDAY  = 8'h01,
    parameter logic [2:0] INIT_WDAY  = 3'd1,
    parameter logic [7:0] INIT_HOUR  = 8'h00,
    parameter logic [7:0] INIT_MIN   = 8'h00,
    parameter logic [7:0] INIT_SEC   = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic       hold,
    input  logic       clear,
    input  logic       adj_min,
    input  logic       adj_day,
    input  logic       adj_rate,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [2:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);

    tod_t  tod;
    date_t date;
    logic  run;
    logic  clr_time;
    logic  min_step;
    logic  day_step;
    logic  tick_ok;
    logic  day_roll;

    // Priority: hold, then clear, then adjust, then the seconds pulse.
    assign run      = ~hold;
    assign clr_time = run & clear;
    assign min_step = run & ~clear & adj_min & adj_rate;
    assign day_step = run & ~clear & adj_day & adj_rate;
    assign tick_ok  = run & ~clear & sec_tick & ~min_step & ~day_step;

    cal_time_chain #(
        .RST_HOUR(INIT_HOUR),
        .RST_MIN (INIT_MIN),
        .RST_SEC (INIT_SEC)
    ) u_time (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_time),
        .tick     (tick_ok),
        .min_adj  (min_step),
        .tod      (tod),
        .day_carry(day_roll)
    );

    cal_date_chain #(
        .RST_YEAR (INIT_YEAR),
        .RST_MONTH(INIT_MONTH),
        .RST_MDAY (INIT_MDAY),
        .RST_WDAY (INIT_WDAY)
    ) u_date (
        .clk    (clk),
        .rst    (rst),
        .roll   (day_roll),
        .day_adj(day_step),
        .date   (date)
    );

    assign sec_o   = tod.second;
    assign min_o   = tod.minute;
    assign hour_o  = tod.hour;
    assign wday_o  = date.wday;
    assign mday_o  = date.mday;
    assign month_o = date.month;
    assign year_o  = date.year;

endmodule

// File: rtl/cal_clock_core_chk.sv
module cal_clock_core_chk
    import cal_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sec_tick,
    input logic       hold,
    input logic       clear,
    input logic       adj_min,
    input logic       adj_day,
    input logic       adj_rate,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [2:0] wday_o,
    input logic [7:0] mday_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o
);

    AST_TIME_RANGE: assert property (@(posedge clk) disable iff (rst)
        (sec_o[3:0] <= 4'd9 && sec_o <= 8'h59 && min_o[3:0] <= 4'd9 && min_o <= 8'h59
         && hour_o[3:0] <= 4'd9 && hour_o <= 8'h23)); // R3

    AST_DAY_IN_MONTH: assert property (@(posedge clk) disable iff (rst)
        (mday_o >= 8'h01 && mday_o[3:0] <= 4'd9 &&
         mday_o <= month_last_day(bcd2_t'(month_o), leap_year(bcd2_t'(year_o))))); // R4

    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (rst)
        (wday_o >= 3'd1 && wday_o <= 3'd7)); // R7

    AST_WDAY_WITH_DAY: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mday_o) |-> !$stable(wday_o))); // R7

    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (rst)
        ((!$stable(year_o) && $past(year_o) == 8'h99) |-> (year_o == 8'h00 && month_o == 8'h01))); // R6

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (hold |=> $stable({year_o, month_o, mday_o, wday_o, hour_o, min_o, sec_o}))); // R8

    AST_CLEAR_TIME: assert property (@(posedge clk) disable iff (rst)
        ((clear && !hold) |=> (sec_o == 8'h00 && min_o == 8'h00 && hour_o == 8'h00
                               && $stable({year_o, month_o, mday_o, wday_o})))); // R9

    AST_MIN_ADJ_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        ((adj_min && adj_rate && !hold && !clear) |=> ($stable(hour_o) && $stable(sec_o)))); // R10

    AST_DAY_ADJ_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        ((adj_day && adj_rate && !hold && !clear) |=> ($stable(month_o) && $stable(year_o)))); // R11

    AST_NO_RATE_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((!sec_tick && !clear && !hold && !adj_rate) |=>
         $stable({year_o, month_o, mday_o, wday_o, hour_o, min_o, sec_o}))); // R12

endmodule

bind cal_clock_core cal_clock_core_chk u_chk (.*);

// File: tb/sim_cal_clock_core.sv
module sim_cal_clock_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0, hold = 1'b0, clear = 1'b0;
    logic       adj_min = 1'b0, adj_day = 1'b0, adj_rate = 1'b0;
    logic [7:0] sec_o, min_o, hour_o, mday_o, month_o, year_o;
    logic [2:0] wday_o;

    always #2 clk = ~clk;

    cal_clock_core #(
        .INIT_YEAR (8'h99), .INIT_MONTH(8'h12), .INIT_MDAY(8'h31), .INIT_WDAY(3'd7),
        .INIT_HOUR (8'h23), .INIT_MIN  (8'h59), .INIT_SEC (8'h50)
    ) u0 (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .hold(hold), .clear(clear),
        .adj_min(adj_min), .adj_day(adj_day), .adj_rate(adj_rate),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .mday_o(mday_o), .month_o(month_o), .year_o(year_o)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state, plain integers.
    int m_sec = 50, m_min = 59, m_hr = 23, m_day = 31, m_mon = 12, m_yr = 99, m_wd = 7;

    logic [50:0] exp_q[$];
    string       tag_q[$];

    function automatic int mlen(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] tobcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [50:0] model_state();
        return {tobcd(m_yr), tobcd(m_mon), tobcd(m_day), 3'(m_wd),
                tobcd(m_hr), tobcd(m_min), tobcd(m_sec)};
    endfunction

    function automatic logic [50:0] dut_state();
        return {year_o, month_o, mday_o, wday_o, hour_o, min_o, sec_o};
    endfunction

    task automatic next_day_model();
        if (m_day == mlen(m_mon, m_yr)) begin
            m_day = 1;
            m_mon = m_mon + 1;
            if (m_mon == 13) begin
                m_mon = 1;
                m_yr = (m_yr + 1) % 100;
            end
        end else begin
            m_day = m_day + 1;
        end
        m_wd = (m_wd == 7) ? 1 : m_wd + 1;
    endtask

    // Driver: one clock cycle of stimulus, expected result queued.
    task automatic cyc(input bit tk, input bit hd, input bit cl, input bit am,
                       input bit ad, input bit rt, input string tag);
        bit ams, ads;
        @(negedge clk);
        sec_tick = tk; hold = hd; clear = cl; adj_min = am; adj_day = ad; adj_rate = rt;
        ams = am && rt;
        ads = ad && rt;
        if (hd) begin
            // frozen
        end else if (cl) begin
            m_sec = 0; m_min = 0; m_hr = 0;
        end else begin
            if (ams) m_min = (m_min + 1) % 60;
            if (ads) begin
                m_day = (m_day == mlen(m_mon, m_yr)) ? 1 : m_day + 1;
                m_wd  = (m_wd == 7) ? 1 : m_wd + 1;
            end
            if (!ams && !ads && tk) begin
                m_sec = m_sec + 1;
                if (m_sec == 60) begin
                    m_sec = 0;
                    m_min = m_min + 1;
                    if (m_min == 60) begin
                        m_min = 0;
                        m_hr = m_hr + 1;
                        if (m_hr == 24) begin
                            m_hr = 0;
                            next_day_model();
                        end
                    end
                end
            end
        end
        exp_q.push_back(model_state());
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        sec_tick = 0; hold = 0; clear = 0; adj_min = 0; adj_day = 0; adj_rate = 0;
    endtask

    // Monitor: compares each queued expectation one step after its edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [50:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (dut_state() !== e) begin
                    failures++;
                    $display("FAIL %s state act=%h exp=%h", t, dut_state(), e);
                end
            end
        end
    end

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic fast_day(input string tag);
        for (int h = 0; h < 24; h++) begin
            for (int k = 0; k < 59; k++) cyc(0, 0, 0, 1, 0, 1, tag);
            for (int k = 0; k < 60; k++) cyc(1, 0, 0, 0, 0, 0, "R2");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: power-up instant from parameters
        check_eq("R1", {year_o, month_o, mday_o, 5'd0, wday_o}, {8'h99, 8'h12, 8'h31, 8'h07});
        check_eq("R1", {hour_o, min_o, sec_o}, {8'h23, 8'h59, 8'h50});

        // R6: rollover out of 99-12-31 23:59:59
        for (int k = 0; k < 10; k++) cyc(1, 0, 0, 0, 0, 0, "R6");
        check_eq("R6", {year_o, month_o, mday_o}, {8'h00, 8'h01, 8'h01});
        check_eq("R7", {5'd0, wday_o}, 8'h01);

        // R2: plain counting with seconds carry
        for (int k = 0; k < 75; k++) cyc(1, 0, 0, 0, 0, 0, "R2");
        check_eq("R2", {min_o, sec_o}, {8'h01, 8'h15});

        // R8: hold beats every other input
        for (int k = 0; k < 3; k++) cyc(1, 1, 1, 1, 1, 1, "R8");
        check_eq("R8", {hour_o, min_o, sec_o}, {8'h00, 8'h01, 8'h15});

        // R12: adjust without rate strobe does nothing; ticks still count
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 1, 0, "R12");
        cyc(1, 0, 0, 1, 1, 0, "R12");
        check_eq("R12", {mday_o, min_o, sec_o}, {8'h01, 8'h01, 8'h16});

        // R10: minute adjust wraps without hour carry, tick dropped
        for (int k = 0; k < 60; k++) cyc(1, 0, 0, 1, 0, 1, "R10");
        check_eq("R10", {hour_o, min_o, sec_o}, {8'h00, 8'h01, 8'h16});

        // R9: clear zeroes time only
        cyc(1, 0, 1, 0, 0, 0, "R9");
        check_eq("R9", {hour_o, min_o, sec_o, year_o, month_o, mday_o},
                 {8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01});

        // R11: 31 day adjusts in month 01 come back to 01, weekday 1 -> 4
        for (int k = 0; k < 31; k++) cyc(0, 0, 0, 0, 1, 1, "R11");
        check_eq("R11", {month_o, mday_o, 5'd0, wday_o}, {8'h01, 8'h01, 8'h04});

        // R4: end of a 31-day month rolls into month 02
        for (int k = 0; k < 30; k++) cyc(0, 0, 0, 0, 1, 1, "R11");
        check_eq("R4", mday_o, 8'h31);
        fast_day("R3");
        check_eq("R4", {month_o, mday_o, hour_o, min_o, sec_o},
                 {8'h02, 8'h01, 8'h00, 8'h00, 8'h00});

        // R5: year 00 is leap, February reaches 29
        for (int k = 0; k < 28; k++) cyc(0, 0, 0, 0, 1, 1, "R5");
        check_eq("R5", mday_o, 8'h29);
        cyc(0, 0, 0, 0, 1, 1, "R5");
        check_eq("R5", {month_o, mday_o}, {8'h02, 8'h01});

        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule